// File: doc/BRIEF.md
# Chunked SPI Master with Per-Word Length and Chip-Select Hold

This block is a register-mapped SPI master for a single slave. Software pushes transmit words into a four-entry queue. Each word can carry its own bit count, so one word can hold one, two or three bytes. The slave's answer comes back as one right-aligned word per chunk in a four-entry receive queue.

Chip-select is controlled by the address that a word is written to. One data address keeps the slave selected after the chunk, so a longer frame can be built from several chunks. The other data address deselects the slave once its chunk and the idle gap after it have finished. Both data addresses pop the receive queue when read.

The serial clock rate comes from a divider of the system clock. Clock polarity, the launch edge of the output data, the capture edge of the input data, and the bit order in each direction are all programmable. After every chunk the clock is held idle for two serial periods. One interrupt line combines an idle condition and a transmit-queue-empty condition, and each has its own enable.

Top module: `vw_spi_master`

## Requirements
- R1: After reset the status word (address 0x08) reads 0x0000_0280: transmit-empty (bit 9) and receive-empty (bit 7) are set, all other fields are 0. cs_n is high and irq is low.
- R2: Control word A is at 0x00 and reads back exactly as written. Control word B is at 0x04 and keeps only bits 7, 6 and 1, reading 0 in all other bits.
- R3: When A bit 14 is set, a transmit word's bits [31:24] give the chunk length (values above 32 act as 32). The payload is left-aligned in [23:0] when A bit 6 (output MSB-first) is set, and is sent from bit 0 upward when A bit 6 is clear.
- R4: When A bit 14 is clear, the chunk length is A[5:0] (values above 32 act as 32). The whole word is the payload, sent from bit 31 downward with MSB-first output and from bit 0 upward otherwise.
- R5: Each chunk pushes one receive word with the received bits right-aligned. With B bit 1 set, the last bit received is bit 0. With B bit 1 clear, the first bit received is bit 0.
- R6: The serial clock runs at the system clock divided by 2×(A[31:20]+1). Every half period lasts exactly A[31:20]+1 cycles.
- R7: sclk idles at A bit 7. A bit 8 set moves output launch to the leading edge, and A bit 10 set moves input capture to the trailing edge. When a bit is clear, launch happens before the leading edge and capture happens on the leading edge.
- R8: cs_n goes low when a chunk starts and stays low on every clock edge of the chunk. After a chunk written to 0x30, cs_n stays low. After a chunk written to 0x20, cs_n goes high at the end of the gap that follows it.
- R9: Between the last clock edge of one chunk and the first edge of the next, sclk stays idle for at least two serial periods.
- R10: Both queues hold 4 entries. A write to a full transmit queue is dropped. A chunk starts only when the receive queue has room, so no received word is lost. A read of 0x20 or 0x30 with an empty receive queue returns 0 and changes nothing.
- R11: The status word holds the transmit level in [31:24], the receive level in [23:16], transmit-full in bit 10, transmit-empty in bit 9, receive-full in bit 8, receive-empty in bit 7, busy in bit 6 and the bits still to shift in [5:0]. Busy is set while the transmit queue holds a word or a chunk or its gap is in progress.
- R12: While A bit 9 is set, both queues are empty, transmit writes are dropped, the shifter is idle and cs_n is high. Chunks start only while A bit 11 is set.
- R13: irq is high when (B bit 7 is set and busy is clear) or (B bit 6 is set and the transmit queue is empty).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the receive queue at data addresses) |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as bus_rd |
| irq | output | 1 | Combined idle / transmit-empty interrupt |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| cs_n | output | 1 | Active-low slave select |
| miso | input | 1 | Serial data in |

## Verification
A bus write into the transmit queue can land in the same cycle that the shifter takes the head word. Both can also happen while the receive queue is filling. The bench provokes this by writing up to four chunks back to back with a divider of 0–2. In that case the shifter pulls the first word while the later writes are still arriving.

The result is judged at the pins. MISO is looped back from MOSI. The bench checks that every captured serial bit, every receive word and its order, and the final chip-select level match values the bench derives from the written words alone.

// File: rtl/vws_pkg.sv
package vws_pkg;
  localparam logic [7:0] A_CTRL0     = 8'h00;
  localparam logic [7:0] A_CTRL1     = 8'h04;
  localparam logic [7:0] A_STAT      = 8'h08;
  localparam logic [7:0] A_PEEK      = 8'h0C;
  localparam logic [7:0] A_DATA_END  = 8'h20;
  localparam logic [7:0] A_DATA_HOLD = 8'h30;

  typedef enum logic [1:0] {ENG_IDLE, ENG_SHIFT, ENG_GAP} eng_st_e;

  // bit count of a chunk, clamped to the 32-bit shifter
  function automatic logic [5:0] chunk_len(input logic [31:0] w, input logic var_en,
                                           input logic [5:0] fixed);
    logic [7:0] n;
    n = var_en ? w[31:24] : {2'b00, fixed};
    return (n > 8'd32) ? 6'd32 : n[5:0];
  endfunction

  // place the payload where the shifter expects its first bit
  function automatic logic [31:0] load_word(input logic [31:0] w, input logic var_en,
                                            input logic msb);
    if (!var_en) return w;
    return msb ? {w[23:0], 8'h00} : {8'h00, w[23:0]};
  endfunction

  function automatic logic next_bit(input logic [31:0] sr, input logic msb);
    return msb ? sr[31] : sr[0];
  endfunction

  function automatic logic [31:0] shift_out(input logic [31:0] sr, input logic msb);
    return msb ? {sr[30:0], 1'b0} : {1'b0, sr[31:1]};
  endfunction

  function automatic logic [31:0] shift_in(input logic [31:0] sr, input logic b, input logic msb);
    return msb ? {sr[30:0], b} : {b, sr[31:1]};
  endfunction

  // received bits end up right-aligned in either order
  function automatic logic [31:0] align_rx(input logic [31:0] sr, input logic [5:0] len,
                                           input logic msb);
    if (msb) return sr;
    return sr >> (7'd32 - {1'b0, len});
  endfunction
endpackage

// File: rtl/vws_fifo.sv
module vws_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] rp, wp;
  logic [LW-1:0] cnt;
  logic          do_push, do_pop;

  function automatic logic [PW-1:0] inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt == LW'(DEPTH));
  assign empty   = (cnt == '0);
  assign level   = cnt;
  assign dout    = mem[rp];
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  always_ff @(posedge clk)
    if (do_push && !flush) mem[wp] <= din;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rp <= '0; wp <= '0; cnt <= '0;
    end else if (flush) begin
      rp <= '0; wp <= '0; cnt <= '0;
    end else begin
      if (do_push) wp <= inc(wp);
      if (do_pop)  rp <= inc(rp);
      cnt <= cnt + LW'(do_push) - LW'(do_pop);
    end
endmodule

// File: rtl/vws_engine.sv
module vws_engine import vws_pkg::*; #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             en,
  input  logic [DIV_W-1:0] speed,
  input  logic             cpol,
  input  logic             cpha_out,
  input  logic             cpha_in,
  input  logic             msb_out,
  input  logic             msb_in,
  input  logic             var_en,
  input  logic [5:0]       fixed_len,
  input  logic             tx_valid,
  input  logic [31:0]      tx_word,
  input  logic             tx_end,
  input  logic             rx_room,
  output logic             tx_take,
  output logic             rx_push,
  output logic [31:0]      rx_word,
  output logic             active,
  output logic [5:0]       bits_left,
  output logic             edge_lead,
  output logic             edge_trail,
  output logic             sclk,
  output logic             mosi,
  output logic             cs_n,
  input  logic             miso
);
  eng_st_e          st;
  logic [DIV_W-1:0] hcnt;
  logic             half, endf, push_pend, tick;
  logic [1:0]       gcnt;
  logic [31:0]      tsr, rsr, ld;
  logic [5:0]       len, left, ld_len;

  assign tick       = (hcnt == speed);
  assign ld_len     = chunk_len(tx_word, var_en, fixed_len);
  assign ld         = load_word(tx_word, var_en, msb_out);
  assign tx_take    = (st == ENG_IDLE) && en && !flush && tx_valid && rx_room;
  assign edge_lead  = (st == ENG_SHIFT) && tick && !half;
  assign edge_trail = (st == ENG_SHIFT) && tick && half;
  assign rx_push    = push_pend;
  assign rx_word    = align_rx(rsr, len, msb_in);
  assign active     = (st != ENG_IDLE);
  assign bits_left  = left;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= ENG_IDLE; hcnt <= '0; half <= 1'b0; gcnt <= '0;
      tsr <= '0; rsr <= '0; len <= '0; left <= '0;
      endf <= 1'b0; push_pend <= 1'b0;
      sclk <= 1'b0; mosi <= 1'b0; cs_n <= 1'b1;
    end else begin
      push_pend <= 1'b0;
      if (flush) begin
        st <= ENG_IDLE; hcnt <= '0; half <= 1'b0; left <= '0;
        sclk <= cpol; cs_n <= 1'b1;
      end else begin
        case (st)
          ENG_IDLE: begin
            sclk <= cpol; hcnt <= '0; half <= 1'b0;
            if (tx_take) begin
              len <= ld_len; left <= ld_len; endf <= tx_end;
              rsr <= '0; cs_n <= 1'b0;
              if (!cpha_out) begin
                mosi <= next_bit(ld, msb_out);
                tsr  <= shift_out(ld, msb_out);
              end else begin
                tsr  <= ld;
              end
              if (ld_len == 6'd0) begin
                st <= ENG_GAP; gcnt <= '0; push_pend <= 1'b1;
              end else begin
                st <= ENG_SHIFT;
              end
            end
          end
          ENG_SHIFT: begin
            hcnt <= tick ? '0 : hcnt + 1'b1;
            if (tick) begin
              half <= ~half;
              sclk <= ~sclk;
              if (!half) begin
                if (cpha_out) begin
                  mosi <= next_bit(tsr, msb_out);
                  tsr  <= shift_out(tsr, msb_out);
                end
                if (!cpha_in) rsr <= shift_in(rsr, miso, msb_in);
              end else begin
                if (cpha_in) rsr <= shift_in(rsr, miso, msb_in);
                left <= left - 6'd1;
                if (left == 6'd1) begin
                  st <= ENG_GAP; gcnt <= '0; push_pend <= 1'b1;
                end else if (!cpha_out) begin
                  mosi <= next_bit(tsr, msb_out);
                  tsr  <= shift_out(tsr, msb_out);
                end
              end
            end
          end
          ENG_GAP: begin
            hcnt <= tick ? '0 : hcnt + 1'b1;
            if (tick) begin
              gcnt <= gcnt + 2'd1;
              if (gcnt == 2'd3) begin
                st <= ENG_IDLE;
                if (endf) cs_n <= 1'b1;
              end
            end
          end
          default: st <= ENG_IDLE;
        endcase
      end
    end
endmodule

// File: rtl/vw_spi_master.sv
module vw_spi_master import vws_pkg::*; #(
  parameter int DEPTH = 4,
  parameter int DIV_W = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq,
  output logic        sclk,
  output logic        mosi,
  output logic        cs_n,
  input  logic        miso
);
  localparam int LW = $clog2(DEPTH + 1);

  logic [31:0]   ctrl0_q, ctrl1_q;
  logic          clr, data_addr, wr_tx, rd_rx;
  logic          tx_full, tx_empty, rx_full, rx_empty, busy;
  logic [LW-1:0] tx_level, rx_level;
  logic [32:0]   tx_head;
  logic [31:0]   rx_head, rx_word;
  logic          tx_take, rx_push, eng_active, edge_lead, edge_trail, cpol_w;
  logic [5:0]    bits_left;

  assign clr       = ctrl0_q[9];
  assign cpol_w    = ctrl0_q[7];
  assign data_addr = (bus_addr == A_DATA_END) || (bus_addr == A_DATA_HOLD);
  assign wr_tx     = bus_wr && data_addr && !clr;
  assign rd_rx     = bus_rd && data_addr;
  assign busy      = !tx_empty || eng_active;
  assign irq       = (ctrl1_q[7] && !busy) || (ctrl1_q[6] && tx_empty);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctrl0_q <= '0;
      ctrl1_q <= '0;
    end else if (bus_wr) begin
      if (bus_addr == A_CTRL0) ctrl0_q <= bus_wdata;
      if (bus_addr == A_CTRL1) ctrl1_q <= bus_wdata & 32'h0000_00C2;
    end

  always_comb begin
    case (bus_addr)
      A_CTRL0:     bus_rdata = ctrl0_q;
      A_CTRL1:     bus_rdata = ctrl1_q;
      A_STAT:      bus_rdata = {8'(tx_level), 8'(rx_level), 5'b0, tx_full, tx_empty,
                                rx_full, rx_empty, busy, bits_left};
      A_PEEK,
      A_DATA_END,
      A_DATA_HOLD: bus_rdata = rx_empty ? 32'h0 : rx_head;
      default:     bus_rdata = 32'h0;
    endcase
  end

  vws_fifo #(.W(33), .DEPTH(DEPTH), .LW(LW)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(clr),
    .push(wr_tx), .din({bus_addr == A_DATA_END, bus_wdata}),
    .pop(tx_take), .dout(tx_head), .level(tx_level),
    .full(tx_full), .empty(tx_empty));

  vws_fifo #(.W(32), .DEPTH(DEPTH), .LW(LW)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(clr),
    .push(rx_push), .din(rx_word),
    .pop(rd_rx), .dout(rx_head), .level(rx_level),
    .full(rx_full), .empty(rx_empty));

  vws_engine #(.DIV_W(DIV_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .flush(clr), .en(ctrl0_q[11]),
    .speed(ctrl0_q[20 +: DIV_W]), .cpol(cpol_w),
    .cpha_out(ctrl0_q[8]), .cpha_in(ctrl0_q[10]),
    .msb_out(ctrl0_q[6]), .msb_in(ctrl1_q[1]),
    .var_en(ctrl0_q[14]), .fixed_len(ctrl0_q[5:0]),
    .tx_valid(!tx_empty), .tx_word(tx_head[31:0]), .tx_end(tx_head[32]),
    .rx_room(!rx_full), .tx_take(tx_take), .rx_push(rx_push), .rx_word(rx_word),
    .active(eng_active), .bits_left(bits_left),
    .edge_lead(edge_lead), .edge_trail(edge_trail),
    .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .miso(miso));
endmodule

// File: rtl/vws_chk.sv
module vws_chk #(
  parameter int DEPTH = 4,
  parameter int LW    = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tx_take,
  input logic          rx_push,
  input logic          rx_full,
  input logic          eng_active,
  input logic          cs_n,
  input logic          sclk,
  input logic          cpol,
  input logic [LW-1:0] tx_level,
  input logic [LW-1:0] rx_level
);
  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level <= LW'(DEPTH)) && (rx_level <= LW'(DEPTH)));

  // R10
  rx_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> !rx_full);

  // R8
  cs_on_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_take |=> (!cs_n && eng_active));

  // R8
  cs_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(eng_active) && eng_active && (sclk != $past(sclk))) |-> !cs_n);

  // R7
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(eng_active) |-> (sclk == $past(cpol)));
endmodule

bind vw_spi_master vws_chk #(.DEPTH(DEPTH), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_take(tx_take), .rx_push(rx_push),
  .rx_full(rx_full), .eng_active(eng_active), .cs_n(cs_n), .sclk(sclk),
  .cpol(cpol_w), .tx_level(tx_level), .rx_level(rx_level));

// File: tb/sim_vw_spi_master.sv
module sim_vw_spi_master;
  localparam int CLK_PER  = 10;
  localparam int WD_LIMIT = 150000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq, sclk, mosi, cs_n, miso;

  assign miso = mosi;

  vw_spi_master u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .miso(miso));

  always #(CLK_PER / 2) clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 1'b0;
  logic [31:0] tw [4];
  bit th [4];

  // serial-side monitor
  bit mon_en = 1'b0, mon_first = 1'b1, cur_cpol = 1'b0, cur_cpha = 1'b0;
  logic sclk_p = 1'b0;
  int last_chg = 0, half_c = 1, per_bad = 0, cs_bad = 0, cap_n = 0;
  bit cap_bits [256];

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  always @(negedge clk) begin
    cyc++;
    if (mon_en && (sclk !== sclk_p)) begin
      if (!mon_first) begin
        int d;
        d = cyc - last_chg;
        if (d != half_c && d < 4 * half_c) per_bad++;
      end
      mon_first = 1'b0;
      last_chg  = cyc;
      if (cs_n) cs_bad++;
      if (((sclk != cur_cpol) != cur_cpha) && cap_n < 256) begin
        cap_bits[cap_n] = mosi;
        cap_n++;
      end
    end
    sclk_p = sclk;
    if (cyc > WD_LIMIT && !done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected < %0d", cyc, WD_LIMIT);
      summary();
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 20000; i++) begin
      bus_read(8'h08, s);
      if (!s[6]) break;
    end
  endtask

  // bench model of the serial stream
  function automatic int exp_len(input logic [31:0] w, input bit vm, input int fl);
    int n;
    n = vm ? int'(w[31:24]) : fl;
    return (n > 32) ? 32 : n;
  endfunction

  function automatic bit exp_bit(input logic [31:0] w, input bit vm, input bit mo, input int k);
    if (vm) return mo ? w[23 - k] : w[k];
    return mo ? w[31 - k] : w[k];
  endfunction

  function automatic logic [31:0] exp_rx(input logic [31:0] w, input bit vm, input bit mo,
                                         input bit mi, input int fl);
    logic [31:0] r;
    int n;
    r = '0;
    n = exp_len(w, vm, fl);
    for (int k = 0; k < n; k++) begin
      if (mi) r = {r[30:0], exp_bit(w, vm, mo, k)};
      else    r[k] = exp_bit(w, vm, mo, k);
    end
    return r;
  endfunction

  task automatic run_xfer(input int spd, input bit cp, input bit ph, input bit mo,
                          input bit mi, input bit vm, input int fl, input int n);
    logic [31:0] c0, r;
    int total, mism, pos;
    c0 = (32'(spd) << 20) | (32'(vm) << 14) | (32'h1 << 11) | (32'(ph) << 10) |
         (32'(ph) << 8) | (32'(cp) << 7) | (32'(mo) << 6) | 32'(fl & 63);
    bus_write(8'h00, c0);
    bus_write(8'h04, 32'(mi) << 1);
    @(negedge clk);
    cur_cpol = cp; cur_cpha = ph; half_c = spd + 1;
    cap_n = 0; per_bad = 0; cs_bad = 0; mon_first = 1'b1; mon_en = 1'b1;
    for (int i = 0; i < n; i++) bus_write(th[i] ? 8'h30 : 8'h20, tw[i]);
    wait_idle();
    mon_en = 1'b0;
    total = 0; mism = 0; pos = 0;
    for (int i = 0; i < n; i++) begin
      int l;
      l = exp_len(tw[i], vm, fl);
      for (int k = 0; k < l; k++) begin
        if (pos < 256 && cap_bits[pos] != exp_bit(tw[i], vm, mo, k)) mism++;
        pos++;
      end
      total += l;
    end
    chk("R3 R4 serial bit count", 32'(cap_n), 32'(total));
    chk("R3 R4 R7 serial bit values", 32'(mism), 32'h0);
    for (int i = 0; i < n; i++) begin
      bus_read(8'h20, r);
      chk("R5 receive word", r, exp_rx(tw[i], vm, mo, mi, fl));
    end
    chk("R6 R9 clock spacing", 32'(per_bad), 32'h0);
    chk("R8 cs low on edges", 32'(cs_bad), 32'h0);
    chk("R8 cs after last chunk", 32'(cs_n), th[n-1] ? 32'h0 : 32'h1);
    chk("R7 sclk idle level", 32'(sclk), 32'(cp));
  endtask

  initial begin
    logic [31:0] r;
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    bus_read(8'h08, r);
    chk("R1 status after reset", r, 32'h0000_0280);
    chk("R1 pins after reset", {29'b0, cs_n, irq, sclk}, 32'h4);

    // R2 register readback
    bus_write(8'h04, 32'hFFFF_FFFF);
    bus_read(8'h04, r);
    chk("R2 control B readback", r, 32'h0000_00C2);
    bus_write(8'h04, 32'h0);
    bus_write(8'h00, 32'hABC0_00C5);
    bus_read(8'h00, r);
    chk("R2 control A readback", r, 32'hABC0_00C5);

    // R3 24-bit chunk, mode 0, MSB-first both ways
    tw[0] = 32'h18A5_C33C; th[0] = 1'b0;
    run_xfer(1, 0, 0, 1, 1, 1, 0, 1);

    // R8 keep-select chunk then release by clear (R12)
    tw[0] = 32'h085A_0000; th[0] = 1'b0;
    tw[1] = 32'h10F0_0F00; th[1] = 1'b1;
    run_xfer(0, 0, 1, 1, 1, 1, 0, 2);
    bus_write(8'h00, 32'h0000_0200);
    @(negedge clk);
    chk("R12 clear releases cs", 32'(cs_n), 32'h1);

    // R4 fixed 12-bit, LSB-first, CPOL=1 CPHA=1
    tw[0] = 32'h0000_0A53; th[0] = 1'b0;
    run_xfer(2, 1, 1, 0, 0, 0, 12, 1);

    // R10 R11 queue limits while shifting is disabled
    bus_write(8'h00, 32'h0000_0000);
    bus_write(8'h04, 32'h0000_0000);
    for (int i = 0; i < 5; i++) bus_write(8'h20, {8'd8, 8'(8'h31 + i), 16'h0});
    bus_read(8'h08, r);
    chk("R10 R11 full transmit status", r, 32'h0400_04C0);
    bus_read(8'h20, r);
    chk("R10 empty receive read", r, 32'h0);
    bus_read(8'h08, r);
    chk("R10 empty read leaves state", r, 32'h0400_04C0);
    bus_write(8'h04, 32'h0000_00C0);
    @(negedge clk);
    chk("R13 busy with queued word", 32'(irq), 32'h0);
    bus_write(8'h04, 32'h0000_0002);
    bus_write(8'h00, 32'h0000_4840);
    wait_idle();
    bus_read(8'h08, r);
    chk("R10 R11 receive full status", r, 32'h0004_0300);
    for (int i = 0; i < 4; i++) begin
      bus_read(8'h20, r);
      chk("R10 receive order", r, 32'(8'h31 + i));
    end
    bus_read(8'h08, r);
    chk("R10 fifth write dropped", r, 32'h0000_0280);

    // R13 interrupt sources
    bus_write(8'h04, 32'h0000_0080);
    @(negedge clk);
    chk("R13 idle interrupt", 32'(irq), 32'h1);
    bus_write(8'h04, 32'h0000_0040);
    @(negedge clk);
    chk("R13 tx-empty interrupt", 32'(irq), 32'h1);
    bus_write(8'h04, 32'h0);
    @(negedge clk);
    chk("R13 interrupts off", 32'(irq), 32'h0);

    // R12 clear empties queued words
    bus_write(8'h00, 32'h0000_0000);
    bus_write(8'h20, 32'h0812_0000);
    bus_write(8'h30, 32'h0834_0000);
    bus_write(8'h00, 32'h0000_0200);
    bus_read(8'h08, r);
    chk("R12 clear empties queues", r, 32'h0000_0280);
    bus_write(8'h20, 32'h0856_0000);
    bus_read(8'h08, r);
    chk("R12 write dropped during clear", r, 32'h0000_0280);

    // random mix
    for (int it = 0; it < 28; it++) begin
      int spd, fl, n;
      bit cp, ph, mo, mi, vm;
      spd = $urandom % 3; cp = 1'($urandom); ph = 1'($urandom);
      mo = 1'($urandom); mi = 1'($urandom); vm = 1'($urandom);
      fl = 1 + ($urandom % 32); n = 1 + ($urandom % 4);
      for (int i = 0; i < 4; i++) begin
        int l;
        case ($urandom % 4)
          0: l = 8;
          1: l = 16;
          2: l = 24;
          default: l = 1 + ($urandom % 24);
        endcase
        tw[i] = vm ? {8'(l), 24'($urandom)} : $urandom;
        th[i] = 1'($urandom);
      end
      run_xfer(spd, cp, ph, mo, mi, vm, fl, n);
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule